// File: doc/BRIEF.md
# Variable-Latency Carry-Skip Adder with Prefix Core

This block is a clocked binary adder for a datapath that can tolerate an occasional extra cycle of latency. The operand word is split into equal ripple stages around a central prefix core. The lowest stage ripples from the incoming carry. Every other ripple stage adds its operand slices with a zero carry-in. It then increments the partial sum by the carry that reaches it. Skip logic forms the carry out of the stage from the stage's own generated carry and from the product of its propagate bits. The central core, eight bits wide by default, replaces a ripple stage with a Kogge-Stone prefix network. Its per-bit carries are resolved from the incoming carry and the prefix group terms once the network has settled.

A small predictor looks at the propagate bits of a few bit positions in the middle of the word. If all of them propagate, a long carry chain may be active. The operation then holds its operands for a second cycle before the result is registered. Otherwise the result is registered one cycle after the operands. The caller presents operands with `in_valid` and must not rely on acceptance while `busy` is high. Each result appears with a single-cycle `out_valid`.

Top module: `hvl_skip_adder`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `out_valid` and `busy` are 0.
- R2: For every accepted operation, `out_sum` equals the low WIDTH bits of in_a + in_b + in_cin, and `out_cout` equals bit WIDTH of that sum.
- R3: An operation is long exactly when in_a XOR in_b is 1 at every bit of the predicted window. With the defaults this window is bits 17 down to 14. A short operation never raises `busy`, and a long operation raises `busy` for exactly one cycle.
- R4: A short operation accepted at a clock edge raises `out_valid` in the cycle after the next edge. No other cycle sits in between.
- R5: A long operation accepted at a clock edge drives `busy` high in the following cycle. Its result appears one cycle later than that of a short operation.
- R6: `in_valid` asserted while `busy` is high is ignored. No extra result is produced, and the pending result keeps the operands of the original operation.
- R7: `out_valid` is high for exactly one cycle per accepted operation. Short operations offered on consecutive cycles are all accepted, and their results come out on consecutive cycles in order.
- R8: Carries that ripple through the whole word are summed correctly. This includes a carry from bit 0 through the prefix core into the carry-out, and a carry generated inside the core that travels through the upper stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present; taken at the clock edge when `busy` is low |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| in_cin | input | 1 | Carry into bit 0 |
| busy | output | 1 | A long operation is in its first cycle; new operands are refused |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_sum | output | WIDTH | Registered sum |
| out_cout | output | 1 | Registered carry out of the top bit |

## Verification
Take the clock edge that accepts an operation as the reference edge. A short result is due one edge later and a long result two edges later. `busy` must be high only in the cycle right after the reference edge of a long operation. The bench drives inputs and samples outputs on falling edges. It computes the window predicate from the operands to decide, per operation, on which falling edge `out_valid` must rise and on which it must already be low again. In the streaming scenario a new short operation enters on every edge. There, the result of the operation driven two falling edges earlier is checked in each cycle.

// File: rtl/hvl_pkg.sv
package hvl_pkg;

  // Which cycle of an operation the operand register is in
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } hvl_phase_e;

endpackage

// File: rtl/hvl_ripple_stage.sv
// Ripple stage. With INCR clear it ripples straight from cin. With INCR set it
// adds with a zero carry-in, then increments the partial sum by cin, and skip
// logic forms the stage carry from the local carry and the propagate product.
module hvl_ripple_stage #(
  parameter int W    = 4,
  parameter bit INCR = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W-1:0] pv;
  logic [W-1:0] gv;
  logic [W-1:0] s0;
  logic [W:0]   rc;

  assign pv = a ^ b;
  assign gv = a & b;

  always_comb begin
    rc[0] = INCR ? 1'b0 : cin;
    for (int i = 0; i < W; i++) begin
      rc[i+1] = gv[i] | (pv[i] & rc[i]);
    end
  end

  assign s0 = pv ^ rc[W-1:0];

  generate
    if (INCR) begin : g_incr
      logic [W-1:0] ic;
      logic         grp_p;

      assign grp_p = &pv;

      always_comb begin
        ic[0] = cin;
        for (int i = 0; i < W - 1; i++) begin
          ic[i+1] = s0[i] & ic[i];
        end
      end

      assign sum  = s0 ^ ic;
      assign cout = rc[W] | (grp_p & cin);
    end else begin : g_plain
      assign sum  = s0;
      assign cout = rc[W];
    end
  endgenerate

endmodule

// File: rtl/hvl_ks_nucleus.sv
// Prefix core: bit propagate/generate, a Kogge-Stone network of log2(W)
// levels, then per-bit carries from cin and the prefix terms, then the sums.
module hvl_ks_nucleus #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  localparam int LVL = $clog2(W);

  logic [W-1:0]           pv;
  logic [W-1:0]           gv;
  logic [LVL:0][W-1:0]    gl;
  logic [LVL:0][W-1:0]    pl;
  logic [W-1:0]           cv;

  assign pv = a ^ b;
  assign gv = a & b;

  always_comb begin
    gl[0] = gv;
    pl[0] = pv;
    for (int k = 1; k <= LVL; k++) begin
      for (int i = 0; i < W; i++) begin
        if (i >= (1 << (k - 1))) begin
          gl[k][i] = gl[k-1][i] | (pl[k-1][i] & gl[k-1][i - (1 << (k - 1))]);
          pl[k][i] = pl[k-1][i] & pl[k-1][i - (1 << (k - 1))];
        end else begin
          gl[k][i] = gl[k-1][i];
          pl[k][i] = pl[k-1][i];
        end
      end
    end
  end

  always_comb begin
    cv[0] = cin;
    for (int i = 1; i < W; i++) begin
      cv[i] = gl[LVL][i-1] | (pl[LVL][i-1] & cin);
    end
  end

  assign sum  = pv ^ cv;
  assign cout = gl[LVL][W-1] | (pl[LVL][W-1] & cin);

endmodule

// File: rtl/hvl_predictor.sv
// Flags a possibly long carry chain: every bit of the window propagates.
module hvl_predictor #(
  parameter int W  = 32,
  parameter int LO = 14,
  parameter int PW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         long_path
);

  logic [PW-1:0] win_p;

  assign win_p     = a[LO +: PW] ^ b[LO +: PW];
  assign long_path = &win_p;

endmodule

// File: rtl/hvl_skip_adder.sv
module hvl_skip_adder
  import hvl_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int STAGE_W = 4,
  parameter int NUC_W   = 8,
  parameter int PRED_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             in_cin,
  output logic             busy,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_cout
);

  localparam int NUC_LO  = (WIDTH - NUC_W) / 2;
  localparam int NUC_HI  = NUC_LO + NUC_W;
  localparam int N_LOW   = NUC_LO / STAGE_W;
  localparam int N_HIGH  = (WIDTH - NUC_HI) / STAGE_W;
  localparam int PRED_LO = (WIDTH - PRED_W) / 2;

  // operand register
  logic [WIDTH-1:0] a_q, b_q;
  logic             cin_q;
  logic             op_q;
  hvl_phase_e       phase_q;

  // result register
  logic [WIDTH-1:0] sum_q;
  logic             cout_q;
  logic             ov_q;

  // next-state
  logic             accept;
  logic             finish;
  logic             busy_w;
  logic             op_d;
  hvl_phase_e       phase_d;
  logic             long_w;

  // datapath
  logic [WIDTH-1:0] dp_sum;
  logic             dp_cout;
  logic [N_LOW:0]   lc;
  logic [N_HIGH:0]  hc;

  // ---------------- carry chain below the core ----------------
  assign lc[0] = cin_q;

  generate
    for (genvar j = 0; j < N_LOW; j++) begin : g_low
      hvl_ripple_stage #(
        .W    (STAGE_W),
        .INCR (j != 0)
      ) u_stage (
        .a    (a_q[j*STAGE_W +: STAGE_W]),
        .b    (b_q[j*STAGE_W +: STAGE_W]),
        .cin  (lc[j]),
        .sum  (dp_sum[j*STAGE_W +: STAGE_W]),
        .cout (lc[j+1])
      );
    end
  endgenerate

  // ---------------- prefix core ----------------
  hvl_ks_nucleus #(
    .W (NUC_W)
  ) u_nucleus (
    .a    (a_q[NUC_LO +: NUC_W]),
    .b    (b_q[NUC_LO +: NUC_W]),
    .cin  (lc[N_LOW]),
    .sum  (dp_sum[NUC_LO +: NUC_W]),
    .cout (hc[0])
  );

  // ---------------- carry chain above the core ----------------
  generate
    for (genvar j = 0; j < N_HIGH; j++) begin : g_high
      hvl_ripple_stage #(
        .W    (STAGE_W),
        .INCR (1'b1)
      ) u_stage (
        .a    (a_q[NUC_HI + j*STAGE_W +: STAGE_W]),
        .b    (b_q[NUC_HI + j*STAGE_W +: STAGE_W]),
        .cin  (hc[j]),
        .sum  (dp_sum[NUC_HI + j*STAGE_W +: STAGE_W]),
        .cout (hc[j+1])
      );
    end
  endgenerate

  assign dp_cout = hc[N_HIGH];

  // ---------------- latency predictor ----------------
  hvl_predictor #(
    .W  (WIDTH),
    .LO (PRED_LO),
    .PW (PRED_W)
  ) u_pred (
    .a         (a_q),
    .b         (b_q),
    .long_path (long_w)
  );

  // ---------------- control next-state ----------------
  always_comb begin
    busy_w  = op_q & long_w & (phase_q == PH_FIRST);
    finish  = op_q & (~long_w | (phase_q == PH_SECOND));
    accept  = in_valid & ~busy_w;
    op_d    = accept | (op_q & ~finish);
    phase_d = busy_w ? PH_SECOND : PH_FIRST;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= 1'b0;
      phase_q <= PH_FIRST;
      ov_q    <= 1'b0;
    end else begin
      op_q    <= op_d;
      phase_q <= phase_d;
      ov_q    <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      cin_q <= 1'b0;
    end else if (accept) begin
      a_q   <= in_a;
      b_q   <= in_b;
      cin_q <= in_cin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else if (finish) begin
      sum_q  <= dp_sum;
      cout_q <= dp_cout;
    end
  end

  assign busy      = busy_w;
  assign out_valid = ov_q;
  assign out_sum   = sum_q;
  assign out_cout  = cout_q;

  // ---------------- assertions ----------------
  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    op_q |-> ({dp_cout, dp_sum} == ({1'b0, a_q} + {1'b0, b_q} + {{WIDTH{1'b0}}, cin_q}))); // R2

  AST_SHORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q && !long_w) |=> out_valid); // R4

  AST_LONG_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && !out_valid) ##1 out_valid); // R5

  AST_BUSY_HOLDS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(b_q) && $stable(cin_q))); // R6

  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !op_q |=> !out_valid); // R7

endmodule

// File: tb/hvl_skip_adder_bench.sv
module hvl_skip_adder_bench;

  localparam int W      = 32;
  localparam int WIN_LO = 14;
  localparam int WIN_W  = 4;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_a;
  logic [W-1:0] in_b;
  logic         in_cin;
  logic         busy;
  logic         out_valid;
  logic [W-1:0] out_sum;
  logic         out_cout;

  int checks;
  int fails;
  bit done;

  hvl_skip_adder u_hvl_skip_adder (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_cin    (in_cin),
    .busy      (busy),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_cout  (out_cout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit ref_long(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] x;
    x = (a ^ b) >> WIN_LO;
    return &x[WIN_W-1:0];
  endfunction

  function automatic logic [W:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_result(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                            input string tag);
    logic [W:0] e;
    e = ref_sum(a, b, c);
    chk({out_cout, out_sum} == e, tag, {31'd0, out_cout, out_sum}, {31'd0, e});
  endtask

  // one operation from an idle adder, with full latency checks
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    bit lng;
    lng = ref_long(a, b);
    @(negedge clk);
    in_a = a; in_b = b; in_cin = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(busy == lng, "R3 busy vs window", {63'd0, busy}, {63'd0, lng});
    chk(out_valid == 1'b0, "R4 no early result", {63'd0, out_valid}, 64'd0);
    if (lng) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && busy == 1'b0, "R5 second cycle",
          {62'd0, out_valid, busy}, 64'd0);
    end
    @(negedge clk);
    chk(out_valid == 1'b1, lng ? "R5 long result due" : "R4 short result due",
        {63'd0, out_valid}, 64'd1);
    chk_result(a, b, c, "R2 sum");
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 single pulse", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; in_cin = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && busy == 1'b0, "R1 in reset", {62'd0, out_valid, busy}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && busy == 1'b0, "R1 after release", {62'd0, out_valid, busy}, 64'd0);
  endtask

  task automatic t_short;
    run_op(32'h1234_5678, 32'h0000_1111, 1'b0);
    run_op(32'h0000_0FFF, 32'h0000_0001, 1'b0);
    run_op(32'hDEAD_0000, 32'h0000_BEEF, 1'b1);
    run_op(32'h0000_0000, 32'h0000_0000, 1'b0);
  endtask

  task automatic t_long;
    run_op(32'h0003_C000, 32'h0000_0000, 1'b0);
    run_op(32'h1234_4321, 32'h0003_C000 ^ 32'h1234_4321, 1'b1);
  endtask

  task automatic t_full_carry;
    // R8: carry from bit 0 through the core to the carry-out
    run_op(32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
    run_op(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    // R8: carry generated at bit 12 inside the core, through upper stages
    run_op(32'hFFFF_F000, 32'h0000_1000, 1'b0);
  endtask

  task automatic t_busy_ignore;
    @(negedge clk);
    in_a = 32'h0003_C005; in_b = 32'h0000_0003; in_cin = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R6 long op busy", {63'd0, busy}, 64'd1);
    in_a = 32'h7777_7777; in_b = 32'h1111_1111; in_cin = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R6 no result yet", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6 original result", {63'd0, out_valid}, 64'd1);
    chk_result(32'h0003_C005, 32'h0000_0003, 1'b0, "R6 operands kept");
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 pulse ends", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 refused op gives no result", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_stream;
    logic [W-1:0] sa [8];
    logic [W-1:0] sb [8];
    logic         sc [8];
    logic [W-1:0] seed;
    seed = 32'h1357_9BDF;
    for (int i = 0; i < 8; i++) begin
      seed  = seed * 32'd1664525 + 32'd1013904223;
      sa[i] = seed & ~(32'h1 << WIN_LO);
      seed  = seed * 32'd1664525 + 32'd1013904223;
      sb[i] = seed & ~(32'h1 << WIN_LO);
      sc[i] = seed[31];
    end
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(busy == 1'b0, "R3 short ops no busy", {63'd0, busy}, 64'd0);
      if (i >= 2) begin
        chk(out_valid == 1'b1, "R7 back-to-back valid", {63'd0, out_valid}, 64'd1);
        chk_result(sa[i-2], sb[i-2], sc[i-2], "R7 in-order result");
      end
      if (i < 8) begin
        in_a = sa[i]; in_b = sb[i]; in_cin = sc[i]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 stream ends", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    t_reset();
    t_short();
    t_long();
    t_full_carry();
    t_busy_ignore();
    t_stream();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule